// File: doc/BRIEF.md
# I2C Slave Register Port

This block lets an external I2C master read and write a bank of sixteen 8-bit registers. SCL and SDA are brought into a fast system clock domain through synchronisers. Line events (SCL edges, start and stop conditions) are derived from the synchronised levels. A byte-level state machine follows each transfer. It matches a fixed 7-bit device address and keeps a register pointer. It acknowledges the bytes it receives and shifts read data out. The block pulls SDA low through an open-drain enable output and never drives it high.

A write transfer carries the device address with the direction bit clear and then a pointer byte. Any bytes after that are stored at consecutive registers. To read, the master first sends a write transfer that carries only the pointer byte, usually closed by a stop. A read transfer then returns bytes from the stored pointer. The pointer survives stop conditions. It advances after every byte written or returned and wraps from register 15 to register 0.

States and transitions:
- `ST_IDLE`: entered on reset and on every stop.
- `ST_DEVADDR`: entered on every start; shifts in the address byte.
- `ST_DEVACK`: entered on a matching address.
- `ST_SKIP`: entered on a mismatching address.
- `ST_PTRBYTE` and `ST_PTRACK`: receive and acknowledge the pointer byte; entered from `ST_DEVACK` on a write.
- `ST_WRBYTE` and `ST_WRACK`: receive, store and acknowledge each data byte; this pair repeats.
- `ST_RDBYTE` and `ST_RDACK`: shift out a byte and take the master's acknowledge; entered from `ST_DEVACK` on a read.
- From `ST_RDACK`, an ACK from the master returns to `ST_RDBYTE`, and a NACK goes to `ST_SKIP`.

Top module: `i2c_regport`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins reception of an address byte from any state, including as a repeated start. A stop condition (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: An address byte whose bits 7:1 equal 7'b1101110 is acknowledged: 0xDC selects a write and 0xDD selects a read. Acknowledging means SDA is held low during the ninth SCL pulse.
- R3: An address byte with any other value in bits 7:1 is not acknowledged. The block then drives nothing and stores nothing until the next start or stop.
- R4: In a write transfer, the byte after the address is acknowledged and its bits 3:0 load the register pointer.
- R5: Each further byte of a write transfer is acknowledged and stored at the pointed register, and the pointer then advances by one.
- R6: The pointer is kept across a stop, so a read transfer returns data starting at the register named by the last pointer byte or left by the last access.
- R7: In a read transfer each byte is sent MSB first, and the pointer advances by one after each byte. The next byte comes from the next register while the master acknowledges.
- R8: A NACK from the master after a read byte ends data output. SDA stays released until a stop or a start.
- R9: The pointer wraps from 15 to 0 in both writes and reads.
- R10: The SDA drive enable changes only while the synchronised SCL is low.
- R11: After reset every register and the pointer are zero, and SDA is released.
- R12: A stop that arrives before a data byte is complete discards the partial byte and leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench aims at the pointer's lifetime. If the pointer were cleared on stop, a read with no pointer byte would return register 0 instead of the continued location. If the pointer did not wrap, a burst across register 15 would lose its last bytes. A foreign address is followed by bytes that look like a pointer and data, so a block that did not ignore it would corrupt register 5. A stop inside a half-sent byte would leave a stray write in register 9 if partial bytes were committed. A read burst closed by a NACK, followed by an extra clocked byte, exposes a block that keeps driving data after the master declines.

// File: rtl/i2c_regport_pkg.sv
`timescale 1ns/1ps
package i2c_regport_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_PTRBYTE,
        ST_PTRACK,
        ST_WRBYTE,
        ST_WRACK,
        ST_RDBYTE,
        ST_RDACK,
        ST_SKIP
    } port_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_in;
                    sda_pipe <= sda_in;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
module i2c_reg_bank #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cells[i] <= '0;
                end else if (wr_en && (wr_addr == AW'(i))) begin
                    cells[i] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/i2c_regport.sv
`timescale 1ns/1ps
module i2c_regport #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101110,
    parameter int         PTR_W       = 4,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import i2c_regport_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    port_state_e       state, state_nxt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [CNT_W-1:0]  bit_cnt;
    logic [PTR_W-1:0]  ptr;
    logic              rd_mode;
    logic              mst_ack;
    logic              byte_full;
    logic              addr_hit;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_reg_bank #(.AW(PTR_W), .DW(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (rx_sh),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    assign byte_full = (bit_cnt == CNT_FULL);
    assign addr_hit  = (rx_sh[DATA_W-1:DATA_W-7] == DEV_ADDR);
    assign wr_en     = (state == ST_WRBYTE) && scl_fall && byte_full;

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (stop_evt) begin
            state_nxt = ST_IDLE;
        end else if (start_evt) begin
            state_nxt = ST_DEVADDR;
        end else begin
            unique case (state)
                ST_IDLE:    state_nxt = ST_IDLE;
                ST_SKIP:    state_nxt = ST_SKIP;
                ST_DEVADDR: if (scl_fall && byte_full)
                                state_nxt = addr_hit ? ST_DEVACK : ST_SKIP;
                ST_DEVACK:  if (scl_fall)
                                state_nxt = rd_mode ? ST_RDBYTE : ST_PTRBYTE;
                ST_PTRBYTE: if (scl_fall && byte_full) state_nxt = ST_PTRACK;
                ST_PTRACK:  if (scl_fall) state_nxt = ST_WRBYTE;
                ST_WRBYTE:  if (scl_fall && byte_full) state_nxt = ST_WRACK;
                ST_WRACK:   if (scl_fall) state_nxt = ST_WRBYTE;
                ST_RDBYTE:  if (scl_fall && (bit_cnt == CNT_LAST)) state_nxt = ST_RDACK;
                ST_RDACK:   if (scl_fall) state_nxt = mst_ack ? ST_RDBYTE : ST_SKIP;
                default:    state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rx_sh   <= '0;
            tx_sh   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            rd_mode <= 1'b0;
            mst_ack <= 1'b0;
        end else begin
            state <= state_nxt;
            if (start_evt || stop_evt) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_DEVADDR, ST_PTRBYTE, ST_WRBYTE: begin
                        if (scl_rise && !byte_full) begin
                            rx_sh   <= {rx_sh[DATA_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                        if (scl_fall && byte_full) begin
                            if (state == ST_DEVADDR) rd_mode <= rx_sh[0];
                            if (state == ST_PTRBYTE) ptr <= rx_sh[PTR_W-1:0];
                            if (state == ST_WRBYTE)  ptr <= ptr + PTR_W'(1);
                        end
                    end
                    ST_DEVACK, ST_PTRACK, ST_WRACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_DEVACK && rd_mode) tx_sh <= rd_data;
                        end
                    end
                    ST_RDBYTE: begin
                        if (scl_fall) begin
                            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b1};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (bit_cnt == CNT_LAST) ptr <= ptr + PTR_W'(1);
                        end
                    end
                    ST_RDACK: begin
                        if (scl_rise) mst_ack <= ~sda_lvl;
                        if (scl_fall && mst_ack) begin
                            tx_sh   <= rd_data;
                            bit_cnt <= '0;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        bit_cnt <= '0;
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            ST_DEVACK, ST_PTRACK, ST_WRACK: sda_oe = 1'b1;
            ST_RDBYTE:                      sda_oe = ~tx_sh[DATA_W-1];
            default:                        sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_regport_chk.sv
`timescale 1ns/1ps
module i2c_regport_chk #(
    parameter int PTR_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          scl_lvl,
    input logic                          start_evt,
    input logic                          stop_evt,
    input logic                          sda_oe,
    input i2c_regport_pkg::port_state_e  state,
    input logic [PTR_W-1:0]              ptr
);
    import i2c_regport_pkg::*;

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (state == ST_DEVADDR));

    assert_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && !sda_oe));

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);

    assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WRBYTE && state == ST_WRACK) |->
            (ptr == PTR_W'($past(ptr) + 1'b1)));

    assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RDBYTE && state == ST_RDACK) |->
            (ptr == PTR_W'($past(ptr) + 1'b1)));

    assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDACK) |-> !sda_oe);

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_lvl));

endmodule

bind i2c_regport i2c_regport_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .state     (state),
    .ptr       (ptr)
);

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
module i2c_regport_test;

    localparam int Q = 8;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int total = 0;
    int bad = 0;
    int r10_viol = 0;
    item_t exp_q[$];
    item_t act_q[$];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regport uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_val(input string tag, input int v);
        exp_q.push_back('{tag: tag, val: v});
    endtask

    task automatic observe(input string tag, input int v);
        act_q.push_back('{tag: tag, val: v});
    endtask

    // monitor: pops expected items and compares with observed ones
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                item_t a;
                item_t e;
                a = act_q.pop_front();
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL %s: actual=0x%0h expected=<none>", a.tag, a.val);
                end else begin
                    e = exp_q.pop_front();
                    if (a.val != e.val) begin
                        bad++;
                        $display("FAIL %s: actual=0x%0h expected=0x%0h", e.tag, a.val, e.val);
                    end
                end
            end
        end
    end

    // R10: drive enable may only move while SCL is low
    logic oe_prev = 1'b0;
    logic scl_prev2 = 1'b1;
    always @(negedge clk) begin
        if (rst_n && (sda_oe != oe_prev) && scl_m && scl_prev2) r10_viol++;
        oe_prev   <= sda_oe;
        scl_prev2 <= scl_m;
    end

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b0; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic clock_bit(input logic drv, output logic smp);
        sda_m = drv;  wq(Q);
        scl_m = 1'b1; wq(Q);
        smp = sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic tx(input logic [7:0] b, input string tag, input int exp_ack);
        logic s;
        expect_val(tag, exp_ack);
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        observe(tag, s ? 0 : 1);
        sda_m = 1'b1;
    endtask

    task automatic tx_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clock_bit(b[i], s);
    endtask

    task automatic rx(input logic mack, input string tag, input int exp_v);
        logic s;
        logic [7:0] got;
        expect_val(tag, exp_v);
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            got[i] = s;
        end
        clock_bit(mack ? 1'b0 : 1'b1, s);
        sda_m = 1'b1;
        observe(tag, int'(got));
    endtask

    task automatic set_ptr(input logic [7:0] p, input string tag);
        bus_start();
        tx(8'hDC, tag, 1);
        tx(p, tag, 1);
        bus_stop();
    endtask

    initial begin
        wq(10);
        rst_n = 1'b1;
        wq(5);

        // R11: reset state
        expect_val("R11", 0); observe("R11", int'(sda_oe));
        bus_start();
        tx(8'hDD, "R2", 1);
        rx(1'b0, "R11", 8'h00);
        bus_stop();

        // R4/R5: burst write from register 0
        bus_start();
        tx(8'hDC, "R2", 1);
        tx(8'h00, "R4", 1);
        tx(8'h11, "R5", 1);
        tx(8'h22, "R5", 1);
        tx(8'h33, "R5", 1);
        bus_stop();

        // R9: write burst across the top of the bank
        bus_start();
        tx(8'hDC, "R4", 1);
        tx(8'h0E, "R4", 1);
        tx(8'hE0, "R5", 1);
        tx(8'hF0, "R5", 1);
        tx(8'h77, "R9", 1);
        bus_stop();

        // R6: no pointer byte, pointer continues at 1; R8 after NACK
        bus_start();
        tx(8'hDD, "R6", 1);
        rx(1'b1, "R6", 8'h22);
        rx(1'b0, "R7", 8'h33);
        expect_val("R8", 0); observe("R8", int'(sda_oe));
        rx(1'b0, "R8", 8'hFF);
        bus_stop();

        // R9/R7: read burst wrapping 15 -> 0
        set_ptr(8'h0F, "R4");
        bus_start();
        tx(8'hDD, "R2", 1);
        rx(1'b1, "R9", 8'hF0);
        rx(1'b1, "R9", 8'h77);
        rx(1'b1, "R7", 8'h22);
        rx(1'b0, "R7", 8'h33);
        bus_stop();

        // R3: foreign addresses are not acknowledged and change nothing
        bus_start();
        tx(8'hA0, "R3", 0);
        tx(8'h05, "R3", 0);
        tx(8'h99, "R3", 0);
        bus_stop();
        bus_start();
        tx(8'hDF, "R3", 0);
        rx(1'b0, "R3", 8'hFF);
        bus_stop();
        set_ptr(8'h05, "R3");
        bus_start();
        tx(8'hDD, "R3", 1);
        rx(1'b0, "R3", 8'h00);
        bus_stop();

        // R1: repeated start turns a pointer write into a read
        bus_start();
        tx(8'hDC, "R1", 1);
        tx(8'h02, "R1", 1);
        bus_start();
        tx(8'hDD, "R1", 1);
        rx(1'b0, "R1", 8'h33);
        bus_stop();
        expect_val("R1", 0); observe("R1", int'(sda_oe));

        // R12: stop inside a data byte
        bus_start();
        tx(8'hDC, "R12", 1);
        tx(8'h08, "R12", 1);
        tx(8'h44, "R12", 1);
        tx_bits(8'hAB, 4);
        bus_stop();
        set_ptr(8'h08, "R12");
        bus_start();
        tx(8'hDD, "R12", 1);
        rx(1'b1, "R12", 8'h44);
        rx(1'b0, "R12", 8'h00);
        bus_stop();

        wq(20);
        wait (act_q.size() == 0);
        wq(2);
        total++;
        if (r10_viol != 0) begin
            bad++;
            $display("FAIL R10: actual=%0d expected=0 (drive changes while SCL high)", r10_viol);
        end
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R1: actual=%0d expected=0 (unconsumed expectations)", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1: actual=hung expected=finished (watchdog)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule